// File: doc/BRIEF.md
# Multi-format serial audio port

This block is a slave stereo serial audio port. An external master supplies the bit clock and the word select. The port samples both in the system clock domain. Playback words that arrive on the serial input are assembled into left/right pairs and handed to the parallel side with a one-cycle strobe. Record words taken from the parallel side are shifted out on the serial output. Each channel occupies 32 bit slots, so the bit clock runs at 64 times the sample rate.

A 3-bit format select picks the framing at run time: the one-slot-delayed standard stereo format, MSB-first with the MSB in the first slot, or end-aligned words of 16, 18 or 20 bits that finish in the last slot of the channel. Parallel words are 20 bits wide and left-aligned. After reset the serial output stays low for a whole number of frames. The number is larger when the DC-cancellation enable is set, because the downstream filter needs longer to settle.

Top module: `audio_serial_port`

## Requirements
- R1: While reset is held and directly after it, sd_out, rx_valid, rx_left and rx_right are all zero.
- R2: fmt_sel 000 selects the delayed standard format. Word bit 19 sits in slot 1 after a word-select change, bit 19-k in slot 1+k, for 20 bits.
- R3: fmt_sel 100 selects MSB-first framing. Word bit 19-k sits in slot k, with slot 0 being the first bit clock after a word-select change.
- R4: fmt_sel 001, 010 and 011 select end-aligned 16-, 18- and 20-bit words. The word's last bit sits in slot 31. Received words are left-aligned in the 20-bit output, with the low bits zero.
- R5: Word select low carries the left word and high carries the right word. rx_valid pulses for exactly one clock per frame, at the start of the following frame, and carries the pair just finished. No pair is reported for the first two frames after reset.
- R6: Serial input bits in slots outside the selected word window have no effect on the received words.
- R7: Output slots outside the selected word window are driven zero.
- R8: fmt_sel codes 101, 110 and 111 carry no data. The output stays zero, and received words read zero while rx_valid still pulses.
- R9: Input and word select are sampled on the rising bit-clock edge. sd_out changes only on the second clock edge after a falling bit-clock edge is presented.
- R10: With dc_cancel_en low, sd_out stays low through MUTE_FRAMES_PLAIN whole frames. These are counted from the first left-channel start seen after reset, and the next frame is audible.
- R11: With dc_cancel_en high, the mute covers MUTE_FRAMES_DC whole frames instead. Once released, the mute does not come back until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bck | input | 1 | Serial bit clock from the master |
| ws | input | 1 | Word select: 0 left, 1 right |
| sd_in | input | 1 | Serial playback data |
| sd_out | output | 1 | Serial record data |
| fmt_sel | input | 3 | Framing select |
| dc_cancel_en | input | 1 | Chooses the longer startup mute |
| tx_left | input | 20 | Left record word, left-aligned |
| tx_right | input | 20 | Right record word, left-aligned |
| rx_left | output | 20 | Received left word, left-aligned |
| rx_right | output | 20 | Received right word, left-aligned |
| rx_valid | output | 1 | One-clock strobe for a new pair |

## Verification
Each line goes through one input register stage before edge detection. A falling bit clock therefore reaches sd_out on the second clock edge after it is applied. A rising bit clock updates the receive state, and any rx_valid pulse, on the second edge as well. The bench holds each bit-clock phase for three clock periods. It reads sd_out on the last clock of the low phase, after both edges have passed. A negedge monitor counts rx_valid pulses over a frame and latches the pair, so each frame's pair is checked during the frame that follows it. Mute release is checked frame by frame against the frame index counted from reset.

// File: rtl/asp_pkg.sv
package asp_pkg;

  typedef enum logic [2:0] {
    FMT_STD   = 3'b000,
    FMT_END16 = 3'b001,
    FMT_END18 = 3'b010,
    FMT_END20 = 3'b011,
    FMT_FIRST = 3'b100
  } fmt_e;

  function automatic logic fmt_known(input logic [2:0] fmt);
    return (fmt <= 3'b100);
  endfunction

  // Position inside a left-aligned word for a given slot, -1 when outside.
  function automatic int slot_bit(input logic [2:0] fmt, input int slot,
                                  input int slots, input int width);
    int first;
    int len;
    int res;
    first = 0;
    len   = 0;
    case (fmt)
      FMT_STD:   begin first = 1; len = width; end
      FMT_FIRST: begin first = 0; len = width; end
      FMT_END16: begin len = (width < 16) ? width : 16; first = slots - len; end
      FMT_END18: begin len = (width < 18) ? width : 18; first = slots - len; end
      FMT_END20: begin len = (width < 20) ? width : 20; first = slots - len; end
      default:   begin first = 0; len = 0; end
    endcase
    res = -1;
    if (len > 0 && slot >= first && slot < first + len)
      res = width - 1 - (slot - first);
    return res;
  endfunction

endpackage

// File: rtl/asp_line_sampler.sv
module asp_line_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic bck,
  input  logic ws,
  input  logic sd,
  output logic bck_rise,
  output logic bck_fall,
  output logic ws_s,
  output logic sd_s
);
  logic bck_d, bck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_d <= 1'b0;
      bck_q <= 1'b0;
      ws_s  <= 1'b0;
      sd_s  <= 1'b0;
    end else begin
      bck_d <= bck;
      bck_q <= bck_d;
      ws_s  <= ws;
      sd_s  <= sd;
    end
  end

  assign bck_rise = bck_d & ~bck_q;
  assign bck_fall = ~bck_d & bck_q;

endmodule

// File: rtl/asp_rx.sv
module asp_rx #(
  parameter int W     = 20,
  parameter int SLOTS = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bck_rise,
  input  logic         ws_s,
  input  logic         sd_s,
  input  logic [2:0]   fmt,
  output logic [W-1:0] rx_left,
  output logic [W-1:0] rx_right,
  output logic         rx_valid
);
  localparam int SW = $clog2(SLOTS);

  logic          ws_prev, ws_prev_n, synced, synced_n, left_ok, left_ok_n;
  logic          valid_n, boundary;
  logic [SW-1:0] slot, slot_n;
  logic [W-1:0]  acc, acc_n, hold, hold_n, rxl_n, rxr_n;
  int            pos;

  always_comb begin
    boundary  = ws_s ^ ws_prev;
    ws_prev_n = ws_s;
    synced_n  = synced | boundary;
    left_ok_n = left_ok;
    hold_n    = hold;
    rxl_n     = rx_left;
    rxr_n     = rx_right;
    valid_n   = 1'b0;
    if (boundary)
      slot_n = '0;
    else if (slot == SW'(SLOTS - 1))
      slot_n = slot;
    else
      slot_n = slot + 1'b1;
    if (boundary && synced) begin
      if (!ws_prev) begin
        hold_n    = acc;
        left_ok_n = 1'b1;
      end else if (left_ok) begin
        rxl_n     = hold;
        rxr_n     = acc;
        valid_n   = bck_rise;
        left_ok_n = 1'b0;
      end
    end
    acc_n = boundary ? '0 : acc;
    pos   = asp_pkg::slot_bit(fmt, int'(slot_n), SLOTS, W);
    for (int i = 0; i < W; i++)
      if (pos == i) acc_n[i] = sd_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_prev  <= 1'b0;
      synced   <= 1'b0;
      left_ok  <= 1'b0;
      slot     <= '0;
      acc      <= '0;
      hold     <= '0;
      rx_left  <= '0;
      rx_right <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= valid_n;
      if (bck_rise) begin
        ws_prev  <= ws_prev_n;
        synced   <= synced_n;
        left_ok  <= left_ok_n;
        slot     <= slot_n;
        acc      <= acc_n;
        hold     <= hold_n;
        rx_left  <= rxl_n;
        rx_right <= rxr_n;
      end
    end
  end

  // R5: a pair strobe lasts one clock and follows a sampled rising edge
  a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r5_strobe_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(bck_rise));

endmodule

// File: rtl/asp_tx.sv
module asp_tx #(
  parameter int W     = 20,
  parameter int SLOTS = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bck_fall,
  input  logic         ws_s,
  input  logic [2:0]   fmt,
  input  logic [W-1:0] tx_left,
  input  logic [W-1:0] tx_right,
  input  logic         mute,
  output logic         frame_start,
  output logic         sd_bit
);
  localparam int SW = $clog2(SLOTS);

  logic          ws_prev, synced, synced_n, boundary, bit_n;
  logic [SW-1:0] slot, slot_n;
  logic [W-1:0]  word, word_n;
  int            pos;

  always_comb begin
    boundary    = ws_s ^ ws_prev;
    synced_n    = synced | boundary;
    frame_start = bck_fall & boundary & ~ws_s;
    if (boundary)
      slot_n = '0;
    else if (slot == SW'(SLOTS - 1))
      slot_n = slot;
    else
      slot_n = slot + 1'b1;
    word_n = boundary ? (ws_s ? tx_right : tx_left) : word;
    pos    = asp_pkg::slot_bit(fmt, int'(slot_n), SLOTS, W);
    bit_n  = 1'b0;
    for (int i = 0; i < W; i++)
      if (pos == i) bit_n = word_n[i];
    bit_n = bit_n & synced_n & ~mute;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_prev <= 1'b0;
      synced  <= 1'b0;
      slot    <= '0;
      word    <= '0;
      sd_bit  <= 1'b0;
    end else if (bck_fall) begin
      ws_prev <= ws_s;
      synced  <= synced_n;
      slot    <= slot_n;
      word    <= word_n;
      sd_bit  <= bit_n;
    end
  end

  // R8: an unused framing code drives nothing but zero
  a_r8_unused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (bck_fall && !asp_pkg::fmt_known(fmt)) |=> !sd_bit);

endmodule

// File: rtl/asp_startup_mute.sv
module asp_startup_mute #(
  parameter int MUTE_FRAMES_PLAIN = 1024,
  parameter int MUTE_FRAMES_DC    = 12288
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic dc_en,
  output logic mute,
  output logic settled
);
  localparam int CW = $clog2(MUTE_FRAMES_DC + 1);

  logic [CW-1:0] cnt, cnt_n, limit;
  logic          settled_n, release_now;

  always_comb begin
    limit       = dc_en ? CW'(MUTE_FRAMES_DC) : CW'(MUTE_FRAMES_PLAIN);
    release_now = frame_start & (cnt >= limit);
    cnt_n       = cnt;
    settled_n   = settled;
    if (frame_start && !settled) begin
      if (cnt >= limit) settled_n = 1'b1;
      else              cnt_n     = cnt + 1'b1;
    end
    mute = ~(settled | release_now);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      settled <= 1'b0;
    end else if (frame_start) begin
      cnt     <= cnt_n;
      settled <= settled_n;
    end
  end

  // R11: once released the mute stays released
  a_r11_mute_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(settled) |-> settled);

endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port #(
  parameter int W                 = 20,
  parameter int SLOTS             = 32,
  parameter int MUTE_FRAMES_PLAIN = 1024,
  parameter int MUTE_FRAMES_DC    = 12288
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bck,
  input  logic         ws,
  input  logic         sd_in,
  output logic         sd_out,
  input  logic [2:0]   fmt_sel,
  input  logic         dc_cancel_en,
  input  logic [W-1:0] tx_left,
  input  logic [W-1:0] tx_right,
  output logic [W-1:0] rx_left,
  output logic [W-1:0] rx_right,
  output logic         rx_valid
);
  logic rst_meta, rst_sn;
  logic bck_rise, bck_fall, ws_s, sd_s;
  logic mute, settled, frame_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sn   <= rst_meta;
    end
  end

  asp_line_sampler u_smp (
    .clk(clk), .rst_n(rst_sn), .bck(bck), .ws(ws), .sd(sd_in),
    .bck_rise(bck_rise), .bck_fall(bck_fall), .ws_s(ws_s), .sd_s(sd_s)
  );

  asp_rx #(.W(W), .SLOTS(SLOTS)) u_rx (
    .clk(clk), .rst_n(rst_sn), .bck_rise(bck_rise), .ws_s(ws_s),
    .sd_s(sd_s), .fmt(fmt_sel), .rx_left(rx_left), .rx_right(rx_right),
    .rx_valid(rx_valid)
  );

  asp_tx #(.W(W), .SLOTS(SLOTS)) u_tx (
    .clk(clk), .rst_n(rst_sn), .bck_fall(bck_fall), .ws_s(ws_s),
    .fmt(fmt_sel), .tx_left(tx_left), .tx_right(tx_right), .mute(mute),
    .frame_start(frame_start), .sd_bit(sd_out)
  );

  asp_startup_mute #(
    .MUTE_FRAMES_PLAIN(MUTE_FRAMES_PLAIN), .MUTE_FRAMES_DC(MUTE_FRAMES_DC)
  ) u_mute (
    .clk(clk), .rst_n(rst_sn), .frame_start(frame_start),
    .dc_en(dc_cancel_en), .mute(mute), .settled(settled)
  );

  // R9: the output moves only one clock after a detected falling edge
  a_r9_out_after_fall: assert property (@(posedge clk) disable iff (!rst_sn)
    !$stable(sd_out) |-> $past(bck_fall));
  // R10: before the mute is released the line is low
  a_r10_mute_low: assert property (@(posedge clk) disable iff (!rst_sn)
    !settled |-> !sd_out);

endmodule

// File: tb/tb_audio_serial_port.sv
module tb_audio_serial_port;
  localparam int SHORT = 2;
  localparam int LONG  = 5;

  logic        clk = 1'b0;
  logic        rst_n, bck, ws, sd_in, dc_en;
  logic [2:0]  fmt;
  logic [19:0] tx_l, tx_r;
  logic        sd_out, rx_valid;
  logic [19:0] rx_l, rx_r;

  int nchk = 0, nfail = 0, vcnt = 0, frame_idx = 0;
  logic [19:0] got_l, got_r, prev_l, prev_r;
  bit finished = 0;

  always #5 clk = ~clk;

  audio_serial_port #(.MUTE_FRAMES_PLAIN(SHORT), .MUTE_FRAMES_DC(LONG)) dut (
    .clk(clk), .rst_n(rst_n), .bck(bck), .ws(ws), .sd_in(sd_in),
    .sd_out(sd_out), .fmt_sel(fmt), .dc_cancel_en(dc_en),
    .tx_left(tx_l), .tx_right(tx_r), .rx_left(rx_l), .rx_right(rx_r),
    .rx_valid(rx_valid)
  );

  always @(negedge clk) if (rx_valid) begin
    vcnt++; got_l = rx_l; got_r = rx_r;
  end

  // Word position of a slot: -1 outside the window.
  function automatic int bpos(input logic [2:0] f, input int k);
    int st, n;
    case (f)
      3'b000: begin st = 1; n = 20; end
      3'b100: begin st = 0; n = 20; end
      3'b001: begin n = 16; st = 32 - n; end
      3'b010: begin n = 18; st = 32 - n; end
      3'b011: begin n = 20; st = 32 - n; end
      default: begin st = 0; n = 0; end
    endcase
    if (k >= st && k < st + n) return 19 - (k - st);
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic dc);
    rst_n = 1'b0; bck = 1'b0; ws = 1'b0; sd_in = 1'b0; dc_en = dc;
    frame_idx = 0;
    repeat (4) @(negedge clk);
    chk(sd_out == 1'b0 && rx_valid == 1'b0, "R1", "outputs in reset",
        {30'd0, sd_out, rx_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rx_l == 20'd0 && rx_r == 20'd0 && sd_out == 1'b0, "R1",
        "outputs after reset", {12'd0, rx_l}, 32'd0);
  endtask

  task automatic run_frame(input logic [19:0] l, input logic [19:0] r,
                           input bit noise, input string req);
    int v0, limit;
    logic [31:0] capl, capr, expl, expr;
    logic [19:0] ml, mr;
    bit audible;
    frame_idx++;
    tx_l = l; tx_r = r;
    v0 = vcnt;
    for (int s = 0; s < 64; s++) begin
      int ch, k, p;
      logic [19:0] w;
      ch = s / 32; k = s % 32;
      w = (ch != 0) ? r : l;
      p = bpos(fmt, k);
      @(negedge clk);
      bck = 1'b0; ws = (ch != 0); sd_in = (p >= 0) ? w[p] : noise;
      repeat (3) @(negedge clk);
      if (ch != 0) capr[k] = sd_out; else capl[k] = sd_out;
      bck = 1'b1;
      repeat (2) @(negedge clk);
    end
    limit   = dc_en ? LONG : SHORT;
    audible = (frame_idx >= limit + 2);
    ml = '0; mr = '0;
    for (int k = 0; k < 32; k++) begin
      int p;
      p = bpos(fmt, k);
      expl[k] = (audible && p >= 0) ? l[p] : 1'b0;
      expr[k] = (audible && p >= 0) ? r[p] : 1'b0;
      if (p >= 0) begin ml[p] = l[p]; mr[p] = r[p]; end
    end
    // Output slot checks also cover R7 (zero fill) and R9 (timing)
    chk(capl == expl, req, "R7 R9 left slots", capl, expl);
    chk(capr == expr, req, "R7 R9 right slots", capr, expr);
    chk((vcnt - v0) == ((frame_idx >= 3) ? 1 : 0), "R5", "strobes per frame",
        vcnt - v0, (frame_idx >= 3) ? 1 : 0);
    if (frame_idx >= 3) begin
      chk(got_l == prev_l, req, "rx left", {12'd0, got_l}, {12'd0, prev_l});
      chk(got_r == prev_r, req, "rx right", {12'd0, got_r}, {12'd0, prev_r});
    end
    prev_l = ml; prev_r = mr;
  endtask

  task automatic t_mute_short();  // R10
    fmt = 3'b000; do_reset(1'b0);
    for (int i = 0; i < 5; i++) run_frame(20'hA5C3F ^ 20'(i), 20'h5A3C1, 1'b0, "R10");
  endtask

  task automatic t_std();  // R2 R5
    run_frame(20'hFFFFF, 20'h00001, 1'b0, "R2");
    run_frame(20'h80000, 20'h7FFFF, 1'b0, "R2");
    run_frame(20'h12345, 20'hEDCBA, 1'b0, "R5");
  endtask

  task automatic t_first();  // R3
    fmt = 3'b100;
    run_frame(20'hC0FFE, 20'h31337, 1'b0, "R3");
    run_frame(20'h80001, 20'h40002, 1'b0, "R3");
  endtask

  task automatic t_end();  // R4 R6
    for (int f = 1; f <= 3; f++) begin
      fmt = 3'(f);
      run_frame(20'hABCDE, 20'h13579, 1'b1, "R4");
      run_frame(20'hFFFFF, 20'h80000, 1'b1, "R6");
    end
  endtask

  task automatic t_unused();  // R8
    fmt = 3'b101;
    run_frame(20'hFFFFF, 20'hFFFFF, 1'b1, "R8");
    fmt = 3'b111;
    run_frame(20'hFFFFF, 20'hAAAAA, 1'b1, "R8");
    run_frame(20'h55555, 20'hFFFFF, 1'b1, "R8");
  endtask

  task automatic t_mute_long();  // R11
    fmt = 3'b000; do_reset(1'b1);
    for (int i = 0; i < 8; i++) run_frame(20'hFEDCB, 20'h3C3C3 ^ 20'(i), 1'b0, "R11");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tx_l = '0; tx_r = '0; fmt = 3'b000;
    t_mute_short();
    t_std();
    t_first();
    t_end();
    t_unused();
    t_mute_long();
    finish_run();
  end

endmodule